// File: doc/BRIEF.md
# Channel Interrupt Enable and Status

This block holds the per-channel interrupt controls of a sixteen-channel timer. A host-side enable register chooses which channels may raise an interrupt. A status register keeps one pending flag per channel. Each flag is set by a one-cycle pulse from that channel's function logic. A single registered request output goes high while any pending channel is also enabled and the 3-bit priority level input is not zero.

The host reaches both registers over a simple single-cycle register bus with one strobe per byte lane. Enable is a word register. Status may be accessed one byte at a time. Clearing a pending flag takes two steps. First the host reads the status register and sees the flag at 1. Then it writes 0 to that bit. Any other write leaves the flag alone. A new set pulse takes priority over a clear and cancels the earlier read. Choosing between channels and producing an interrupt vector are handled outside this block.

Top module: `chan_irq_ctl`

## Requirements
- R1: After reset, all flags, all enables, the request output and the read data are zero.
- R2: The enable register sits at address 0. It is written only when both byte strobes are high, and a write with any strobe low leaves it unchanged. A read of address 0 returns the enable bits.
- R3: A pulse on set line i sets flag i at that clock edge. Any later status read shows the flag.
- R4: The request output at edge N+1 equals the OR over all channels of flag AND enable as held after edge N, forced low when the level input is 0.
- R5: The status register sits at address 1. Writing 0 to a flag bit, with its lane strobe high, clears the flag only if a status read with that lane strobed saw the flag at 1 since it was last set.
- R6: A zero write to a flag that has not been read as 1 since it was last set leaves the flag set.
- R7: Writing 1 to a status bit changes neither the flag nor the permission from an earlier read.
- R8: When a set pulse and a valid clear reach the same flag in the same cycle, the flag stays set and a fresh read is needed before it can be cleared.
- R9: Byte lane k covers status bits 8k+7 down to 8k. A status read or write acts only on lanes whose strobe is high. A read returns 0 in unstrobed lanes and does not grant clear permission there.
- R10: Read data is registered. It is valid in the cycle after the read and holds until the next read.
- R11: A set pulse that arrives after a read and before the zero write cancels the permission from that read, so the zero write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 1 | 0 = enable register, 1 = status register |
| bus_be_i | input | 2 | Byte lane strobes |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| chan_set_i | input | 16 | Per-channel flag set pulses |
| irq_level_i | input | 3 | Interrupt level; zero masks the request |
| irq_req_o | output | 1 | Registered interrupt request |

## Verification
Two events can fall in the same cycle: a channel's set pulse and the host's clearing zero write to the same flag. The bench provokes this by holding a set line high during the write cycle of an armed read-then-write sequence. It then checks that the flag survives and that the permission from the earlier read is gone, because a second zero write is also ignored. The related case, a set pulse between the read and the write, is also driven. The request output is swept over every channel, both enable polarities and all eight level values.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;

  localparam logic ADDR_ENABLE = 1'b0;
  localparam logic ADDR_STATUS = 1'b1;

  typedef struct packed {
    logic en_wr;
    logic en_rd;
    logic st_wr;
    logic st_rd;
  } bus_acc_t;

endpackage

// File: rtl/chan_irq_enable_reg.sv
module chan_irq_enable_reg #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NUM_CH-1:0] wdata,
  output logic [NUM_CH-1:0] enables
);

  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (wr_en) en_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= en_d;
  end

  assign enables = en_q;

endmodule

// File: rtl/chan_irq_flag_bank.sv
module chan_irq_flag_bank #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_pulse,
  input  logic [NUM_CH-1:0] rd_mask,
  input  logic [NUM_CH-1:0] clr_mask,
  output logic [NUM_CH-1:0] flags
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cell
    logic flag_q, flag_d;
    logic arm_q, arm_d;
    logic upd;

    // priority: set, then armed clear, then read arming
    always_comb begin
      flag_d = flag_q;
      arm_d  = arm_q;
      if (set_pulse[i]) begin
        flag_d = 1'b1;
        arm_d  = 1'b0;
      end else if (clr_mask[i] && arm_q) begin
        flag_d = 1'b0;
        arm_d  = 1'b0;
      end else if (rd_mask[i] && flag_q) begin
        arm_d  = 1'b1;
      end
    end

    assign upd = set_pulse[i] | clr_mask[i] | rd_mask[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
        arm_q  <= 1'b0;
      end else if (upd) begin
        flag_q <= flag_d;
        arm_q  <= arm_d;
      end
    end

    assign flags[i] = flag_q;
  end

endmodule

// File: rtl/chan_irq_req_gen.sv
module chan_irq_req_gen #(
  parameter int NUM_CH = 16,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] flags,
  input  logic [NUM_CH-1:0] enables,
  input  logic [LVL_W-1:0]  level,
  output logic              irq
);

  logic req_d, req_q;

  always_comb begin
    req_d = (|(flags & enables)) && (level != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign irq = req_q;

endmodule

// File: rtl/chan_irq_ctl.sv
module chan_irq_ctl
  import chan_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int LVL_W  = 3,
  localparam int LANES = NUM_CH / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic              bus_addr_i,
  input  logic [LANES-1:0]  bus_be_i,
  input  logic [NUM_CH-1:0] bus_wdata_i,
  output logic [NUM_CH-1:0] bus_rdata_o,
  input  logic [NUM_CH-1:0] chan_set_i,
  input  logic [LVL_W-1:0]  irq_level_i,
  output logic              irq_req_o
);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_n_sync = rst_sync_q[1];

  // access decode
  bus_acc_t acc;

  always_comb begin
    acc.en_wr = bus_sel_i &  bus_wr_i & (bus_addr_i == ADDR_ENABLE) & (&bus_be_i);
    acc.en_rd = bus_sel_i & ~bus_wr_i & (bus_addr_i == ADDR_ENABLE);
    acc.st_wr = bus_sel_i &  bus_wr_i & (bus_addr_i == ADDR_STATUS);
    acc.st_rd = bus_sel_i & ~bus_wr_i & (bus_addr_i == ADDR_STATUS);
  end

  logic [NUM_CH-1:0] lane_bits;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_bits[8*k +: 8] = {8{bus_be_i[k]}};
  end

  logic [NUM_CH-1:0] rd_mask, clr_mask;

  always_comb begin
    rd_mask  = acc.st_rd ? lane_bits : '0;
    clr_mask = acc.st_wr ? (lane_bits & ~bus_wdata_i) : '0;
  end

  logic [NUM_CH-1:0] enable_q;
  logic [NUM_CH-1:0] flag_q;

  chan_irq_enable_reg #(.NUM_CH(NUM_CH)) u_enable (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (acc.en_wr),
    .wdata   (bus_wdata_i),
    .enables (enable_q)
  );

  chan_irq_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .set_pulse (chan_set_i),
    .rd_mask   (rd_mask),
    .clr_mask  (clr_mask),
    .flags     (flag_q)
  );

  chan_irq_req_gen #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) u_req (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .flags   (flag_q),
    .enables (enable_q),
    .level   (irq_level_i),
    .irq     (irq_req_o)
  );

  // registered read path
  logic [NUM_CH-1:0] rdata_d, rdata_q;
  logic              rd_any;

  assign rd_any = acc.en_rd | acc.st_rd;

  always_comb begin
    rdata_d = rdata_q;
    if (acc.en_rd)      rdata_d = enable_q;
    else if (acc.st_rd) rdata_d = flag_q & lane_bits;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)  rdata_q <= '0;
    else if (rd_any)  rdata_q <= rdata_d;
  end

  assign bus_rdata_o = rdata_q;

endmodule

// File: rtl/chan_irq_ctl_chk.sv
module chan_irq_ctl_chk #(
  parameter int NUM_CH = 16,
  parameter int LVL_W  = 3,
  localparam int LANES = NUM_CH / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              wr,
  input logic              addr,
  input logic [LANES-1:0]  be,
  input logic [NUM_CH-1:0] set,
  input logic [LVL_W-1:0]  level,
  input logic [NUM_CH-1:0] flags,
  input logic [NUM_CH-1:0] enables,
  input logic              irq
);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((flags & $past(set)) == $past(set)));

  p_set_only_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags) & ~$past(set)) == '0));

  p_clear_needs_status_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flags) & ~flags)) |-> $past(sel && wr && addr == 1'b1));

  p_request_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past((|(flags & enables)) && (level != '0)));

  p_enable_word_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == 1'b0 && !(&be)) |=> $stable(enables));

endmodule

bind chan_irq_ctl chan_irq_ctl_chk #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_sync),
  .sel     (bus_sel_i),
  .wr      (bus_wr_i),
  .addr    (bus_addr_i),
  .be      (bus_be_i),
  .set     (chan_set_i),
  .level   (irq_level_i),
  .flags   (flag_q),
  .enables (enable_q),
  .irq     (irq_req_o)
);

// File: tb/chan_irq_ctl_bench.sv
`timescale 1ns/1ps
module chan_irq_ctl_bench;

  localparam int NUM_CH = 16;
  localparam int LVL_W  = 3;
  localparam int LANES  = NUM_CH / 8;

  logic              clk;
  logic              rst_n;
  logic              bus_sel_i;
  logic              bus_wr_i;
  logic              bus_addr_i;
  logic [LANES-1:0]  bus_be_i;
  logic [NUM_CH-1:0] bus_wdata_i;
  logic [NUM_CH-1:0] bus_rdata_o;
  logic [NUM_CH-1:0] chan_set_i;
  logic [LVL_W-1:0]  irq_level_i;
  logic              irq_req_o;

  chan_irq_ctl #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) u_chan_irq_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_be_i    (bus_be_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .chan_set_i  (chan_set_i),
    .irq_level_i (irq_level_i),
    .irq_req_o   (irq_req_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference state kept from the requirements
  logic [NUM_CH-1:0] m_flag, m_arm, m_en;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NUM_CH-1:0] lanes(input logic [LANES-1:0] be);
    logic [NUM_CH-1:0] m;
    for (int k = 0; k < LANES; k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction

  task automatic do_write(input logic a, input logic [NUM_CH-1:0] d,
                          input logic [LANES-1:0] be, input logic [NUM_CH-1:0] setv);
    logic [NUM_CH-1:0] clr;
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_be_i = be;
    bus_wdata_i = d; chan_set_i = setv;
    @(posedge clk);
    if (a == 1'b0 && (&be)) m_en = d;
    clr = (a == 1'b1) ? (lanes(be) & ~d & m_arm) : '0;
    m_flag = m_flag & ~clr;
    m_arm  = m_arm & ~clr;
    m_flag = m_flag | setv;
    m_arm  = m_arm & ~setv;
    @(negedge clk);
    bus_sel_i = 1'b0; bus_wr_i = 1'b0; chan_set_i = '0;
  endtask

  task automatic do_read(input logic a, input logic [LANES-1:0] be,
                         output logic [NUM_CH-1:0] got, output logic [NUM_CH-1:0] exp);
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = a; bus_be_i = be;
    @(posedge clk);
    if (a == 1'b1) begin
      exp   = m_flag & lanes(be);
      m_arm = m_arm | (m_flag & lanes(be));
    end else begin
      exp = m_en;
    end
    @(negedge clk);
    bus_sel_i = 1'b0;
    got = bus_rdata_o;
  endtask

  task automatic pulse_set(input logic [NUM_CH-1:0] v);
    @(negedge clk);
    chan_set_i = v;
    @(posedge clk);
    m_flag = m_flag | v;
    m_arm  = m_arm & ~v;
    @(negedge clk);
    chan_set_i = '0;
  endtask

  task automatic chk_status(input string req);
    logic [NUM_CH-1:0] g, e;
    do_read(1'b1, '1, g, e);
    chk(req, 32'(g), 32'(e));
  endtask

  task automatic chk_irq(input string req);
    @(posedge clk);
    @(negedge clk);
    chk(req, 32'(irq_req_o), 32'((|(m_flag & m_en)) && (irq_level_i != '0)));
  endtask

  task automatic clear_all();
    logic [NUM_CH-1:0] g, e;
    do_read(1'b1, '1, g, e);
    do_write(1'b1, '0, '1, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NUM_CH-1:0] g, e;
    rst_n = 1'b0;
    bus_sel_i = 1'b0; bus_wr_i = 1'b0; bus_addr_i = 1'b0; bus_be_i = '0;
    bus_wdata_i = '0; chan_set_i = '0; irq_level_i = '0;
    m_flag = '0; m_arm = '0; m_en = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq_req_o), 32'h0);
    chk("R1 rdata", 32'(bus_rdata_o), 32'h0);
    do_read(1'b0, '1, g, e);
    chk("R1 enable", 32'(g), 32'h0);
    do_read(1'b1, '1, g, e);
    chk("R1 status", 32'(g), 32'h0);

    // R2 enable word write, partial strobes ignored
    do_write(1'b0, 16'hA5C3, 2'b11, '0);
    do_read(1'b0, '1, g, e);
    chk("R2 word write", 32'(g), 32'hA5C3);
    do_write(1'b0, 16'h0000, 2'b01, '0);
    do_read(1'b0, '1, g, e);
    chk("R2 low strobe only", 32'(g), 32'hA5C3);
    do_write(1'b0, 16'h0000, 2'b10, '0);
    do_read(1'b0, 2'b01, g, e);
    chk("R2 high strobe only", 32'(g), 32'hA5C3);

    // R10 read data holds until the next read
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 hold", 32'(bus_rdata_o), 32'hA5C3);

    // R3 + R4 sweep: each channel, both enable polarities, all levels
    for (int ch = 0; ch < NUM_CH; ch++) begin
      clear_all();
      pulse_set(NUM_CH'(1) << ch);
      chk_status("R3 set");
      for (int pol = 0; pol < 2; pol++) begin
        do_write(1'b0, pol == 0 ? (NUM_CH'(1) << ch) : ~(NUM_CH'(1) << ch), 2'b11, '0);
        for (int lv = 0; lv < 8; lv++) begin
          @(negedge clk);
          irq_level_i = LVL_W'(lv);
          chk_irq("R4 request");
        end
      end
    end
    clear_all();
    chk_status("R5 clear all");
    do_write(1'b0, 16'hFFFF, 2'b11, '0);
    @(negedge clk);
    irq_level_i = 3'd5;

    // R6 zero write without prior read
    pulse_set(16'h0010);
    do_write(1'b1, 16'h0000, 2'b11, '0);
    chk_status("R6 no read");
    chk("R6 flag kept", 32'(m_flag), 32'h0010);
    // now armed by that read: clear works (R5)
    do_write(1'b1, 16'h0000, 2'b11, '0);
    chk_status("R5 armed clear");
    chk_irq("R4 after clear");

    // R7 write one has no effect
    pulse_set(16'h0008);
    do_read(1'b1, '1, g, e);
    chk("R7 read", 32'(g), 32'h0008);
    do_write(1'b1, 16'hFFFF, 2'b11, '0);
    chk_irq("R7 irq still up");
    do_write(1'b1, 16'hFFF7, 2'b11, '0);
    chk_status("R7 arm kept then cleared");

    // R11 set between read and write cancels arming
    pulse_set(16'h0020);
    do_read(1'b1, '1, g, e);
    pulse_set(16'h0020);
    do_write(1'b1, 16'h0000, 2'b11, '0);
    do_read(1'b1, 2'b01, g, e);
    chk("R11 flag kept", 32'(g), 32'h0020);
    do_write(1'b1, 16'h0000, 2'b11, '0);
    chk_status("R11 cleared after fresh read");

    // R8 set and clear in the same cycle
    pulse_set(16'h0040);
    do_read(1'b1, '1, g, e);
    do_write(1'b1, 16'h0000, 2'b11, 16'h0040);
    do_write(1'b1, 16'h0000, 2'b11, '0);
    do_read(1'b1, '1, g, e);
    chk("R8 set wins", 32'(g), 32'h0040);
    do_write(1'b1, 16'h0000, 2'b11, '0);
    chk_status("R8 later clear");

    // R9 byte lanes
    pulse_set(16'h0101);
    do_read(1'b1, 2'b01, g, e);
    chk("R9 low lane read", 32'(g), 32'h0001);
    do_write(1'b1, 16'h0000, 2'b11, '0);
    do_read(1'b1, 2'b10, g, e);
    chk("R9 only low cleared", 32'(g), 32'h0100);
    do_write(1'b1, 16'h0000, 2'b01, '0);
    do_read(1'b1, '1, g, e);
    chk("R9 high lane untouched", 32'(g), 32'h0100);
    do_write(1'b1, 16'h0000, 2'b10, '0);
    chk_status("R9 high lane cleared");
    chk("R9 empty", 32'(m_flag), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule